// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Selectable Overflow Trap

This block is the integer add and subtract path of a small RISC datapath. It works on 32-bit words. The second operand is either a register value or a 16-bit immediate constant. A 3-bit operation code picks one of six operations: add, add-immediate and subtract, plus an unsigned-named variant of each. All six produce the same wrapped two's-complement result. Only the three signed variants can raise an overflow exception when the true result does not fit in a word. The unsigned-named variants always wrap without any indication.

The arithmetic is combinational. It is followed by one output register with a valid bit, so every accepted operation appears at the outputs exactly one cycle after it is presented. The exception output is a one-cycle pulse that travels with the result it belongs to. When overflow occurs, the result output still carries the truncated low 32 bits. The block only reports overflow. Trapping, writeback and instruction decode belong to the surrounding pipeline.

Top module: `addsub_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `result` is zero and both `out_valid` and `ovf_trap` are low.
- R2: Operation codes: 0 = add, 1 = add-unsigned, 2 = add-immediate, 3 = add-immediate-unsigned, 4 = subtract, 5 = subtract-unsigned. For codes 0 and 1, `result` is `rs_val + rt_val` modulo 2^32.
- R3: For codes 4 and 5, `result` is `rs_val - rt_val` modulo 2^32.
- R4: For codes 2 and 3, the second operand is `imm` sign-extended from 16 to 32 bits, so negative constants such as -10 work. `rt_val` has no effect on the result or on the trap.
- R5: Codes 0 and 2 raise `ovf_trap` exactly when the true signed sum of the two operands lies outside the 32-bit signed range. This is the case where both operands have the same sign and the result sign differs from theirs.
- R6: Code 4 raises `ovf_trap` exactly when the true signed difference lies outside the 32-bit signed range. This is the case where the operands differ in sign and the result sign differs from the sign of `rs_val`.
- R7: Codes 1, 3 and 5 never raise `ovf_trap`, whatever the operand values.
- R8: When `ovf_trap` is raised, `result` shows the truncated low 32 bits of the true result in the same cycle.
- R9: An operation presented with `in_valid` high at a rising edge appears on `result`/`out_valid`/`ovf_trap` after that edge. `out_valid` is high for exactly the cycles that follow a valid input, and `ovf_trap` is high only together with `out_valid`, for one cycle per overflowing operation.
- R10: In a cycle after `in_valid` was low, `result` holds its previous value and `ovf_trap` is low.
- R11: Codes 6 and 7 are reserved. They produce a zero `result` and never raise `ovf_trap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation presented this cycle |
| op | input | 3 | Operation code (see R2, R11) |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| imm | input | 16 | Immediate constant, two's complement |
| out_valid | output | 1 | Registered result is valid |
| result | output | 32 | Registered wrapped result |
| ovf_trap | output | 1 | One-cycle signed overflow exception |

## Verification
The overflow exception and the delivery of the wrapped result always fall in the same output cycle. The bench provokes this with operand pairs at the signed range edges: 0x7FFFFFFF plus 1, 0x80000000 plus itself, 0x80000000 minus 1, and an immediate add that crosses the top of the range. In that one cycle it checks both that the pulse is present and that `result` equals the truncated value. It then applies each pair again under the unsigned-named code and expects the same value with the pulse absent. Back-to-back overflowing and non-overflowing operations check that each pulse lasts one cycle and stays with its own result.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    parameter int unsigned WORD_W = 32;
    parameter int unsigned IMM_W  = 16;
    parameter int unsigned OP_W   = 3;

    localparam int unsigned EXT_W = WORD_W - IMM_W;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 3'd0,
        OP_ADDU  = 3'd1,
        OP_ADDI  = 3'd2,
        OP_ADDIU = 3'd3,
        OP_SUB   = 3'd4,
        OP_SUBU  = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } op_e;

    typedef struct packed {
        logic use_imm;
        logic negate;
        logic trap_en;
        logic kill;
    } ctl_t;

    typedef struct packed {
        logic [WORD_W-1:0] sum;
        logic              ovf;
    } res_t;

    function automatic ctl_t decode_op(input op_e code);
        ctl_t c;
        c = '{use_imm: 1'b0, negate: 1'b0, trap_en: 1'b0, kill: 1'b0};
        case (code)
            OP_ADD:   c.trap_en = 1'b1;
            OP_ADDU:  c.trap_en = 1'b0;
            OP_ADDI:  begin c.use_imm = 1'b1; c.trap_en = 1'b1; end
            OP_ADDIU: c.use_imm = 1'b1;
            OP_SUB:   begin c.negate = 1'b1; c.trap_en = 1'b1; end
            OP_SUBU:  c.negate = 1'b1;
            default:  c.kill = 1'b1;
        endcase
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{EXT_W{v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/addsub_opnd_sel.sv
module addsub_opnd_sel
    import addsub_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [WORD_W-1:0] rs_val,
    input  logic [WORD_W-1:0] rt_val,
    input  logic [IMM_W-1:0]  imm,
    output logic [WORD_W-1:0] opa,
    output logic [WORD_W-1:0] opb,
    output logic              cin,
    output ctl_t              ctl
);
    logic [WORD_W-1:0] second;
    logic [WORD_W-1:0] imm_ext;

    assign ctl     = decode_op(op_e'(op));
    assign imm_ext = sext_imm(imm);

    always_comb begin
        second = ctl.use_imm ? imm_ext : rt_val;
    end

    // Subtraction is done as a + ~b + 1, one inverter per bit.
    genvar gi;
    generate
        for (gi = 0; gi < WORD_W; gi++) begin : g_inv
            assign opb[gi] = second[gi] ^ ctl.negate;
        end
    endgenerate

    assign opa = rs_val;
    assign cin = ctl.negate;

endmodule

// File: rtl/addsub_core.sv
module addsub_core
    import addsub_pkg::*;
(
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    input  logic              cin,
    input  ctl_t              ctl,
    output res_t              res
);
    localparam int unsigned MSB = WORD_W - 1;

    logic [WORD_W-1:0] raw;
    logic              sign_match;
    logic              sign_flip;

    assign raw        = opa + opb + {{(WORD_W-1){1'b0}}, cin};
    assign sign_match = (opa[MSB] == opb[MSB]);
    assign sign_flip  = (raw[MSB] != opa[MSB]);

    always_comb begin
        if (ctl.kill) begin
            res.sum = '0;
            res.ovf = 1'b0;
        end else begin
            res.sum = raw;
            res.ovf = ctl.trap_en & sign_match & sign_flip;
        end
    end

endmodule

// File: rtl/addsub_out_reg.sv
module addsub_out_reg
    import addsub_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  res_t              res,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic              ovf_trap
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            ovf_trap  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            ovf_trap  <= in_valid & res.ovf;
            if (in_valid) begin
                result <= res.sum;
            end
        end
    end

endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
    import addsub_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op,
    input  logic [WORD_W-1:0] rs_val,
    input  logic [WORD_W-1:0] rt_val,
    input  logic [IMM_W-1:0]  imm,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic              ovf_trap
);
    logic [WORD_W-1:0] opa;
    logic [WORD_W-1:0] opb;
    logic              cin;
    ctl_t              ctl;
    res_t              res;

    addsub_opnd_sel u_sel (
        .op     (op),
        .rs_val (rs_val),
        .rt_val (rt_val),
        .imm    (imm),
        .opa    (opa),
        .opb    (opb),
        .cin    (cin),
        .ctl    (ctl)
    );

    addsub_core u_core (
        .opa (opa),
        .opb (opb),
        .cin (cin),
        .ctl (ctl),
        .res (res)
    );

    addsub_out_reg u_oreg (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .res       (res),
        .out_valid (out_valid),
        .result    (result),
        .ovf_trap  (ovf_trap)
    );

endmodule

// File: rtl/addsub_unit_chk.sv
module addsub_unit_chk
    import addsub_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [OP_W-1:0]   op,
    input logic [WORD_W-1:0] rs_val,
    input logic [WORD_W-1:0] rt_val,
    input logic [IMM_W-1:0]  imm,
    input logic              out_valid,
    input logic [WORD_W-1:0] result,
    input logic              ovf_trap
);
    logic is_unsigned_op;
    logic is_reserved_op;
    assign is_unsigned_op = (op == 3'd1) || (op == 3'd3) || (op == 3'd5);
    assign is_reserved_op = (op == 3'd6) || (op == 3'd7);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && !ovf_trap && result == '0));

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r9_no_valid_without_input: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r9_trap_with_valid: assert property (@(posedge clk) disable iff (rst)
        ovf_trap |-> out_valid);

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_unsigned_op) |=> !ovf_trap);

    a_r11_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_reserved_op) |=> (result == '0 && !ovf_trap));

    a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && !ovf_trap));

    a_r2_add_value: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 3'd0 || op == 3'd1)) |=>
            (result == $past(rs_val) + $past(rt_val)));

    a_r3_sub_value: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 3'd4 || op == 3'd5)) |=>
            (result == $past(rs_val) - $past(rt_val)));

endmodule

bind addsub_unit addsub_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .imm       (imm),
    .out_valid (out_valid),
    .result    (result),
    .ovf_trap  (ovf_trap)
);

// File: tb/tb_addsub_unit.sv
`timescale 1ns/1ps
module tb_addsub_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  op;
    logic [31:0] rs_val;
    logic [31:0] rt_val;
    logic [15:0] imm;
    logic        out_valid;
    logic [31:0] result;
    logic        ovf_trap;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    addsub_unit dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op        (op),
        .rs_val    (rs_val),
        .rt_val    (rt_val),
        .imm       (imm),
        .out_valid (out_valid),
        .result    (result),
        .ovf_trap  (ovf_trap)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Reference model built from the requirements using 33-bit true values.
    task automatic model(input logic [2:0] code, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] k, output logic [31:0] r, output logic t);
        logic [32:0] ax, bx, tv;
        logic [31:0] second;
        second = (code == 3'd2 || code == 3'd3) ? {{16{k[15]}}, k} : b;
        ax = {a[31], a};
        bx = {second[31], second};
        tv = (code == 3'd4 || code == 3'd5) ? ax - bx : ax + bx;
        if (code > 3'd5) begin
            r = 32'h0;
            t = 1'b0;
        end else begin
            r = tv[31:0];
            t = (code == 3'd0 || code == 3'd2 || code == 3'd4) && (tv[32] != tv[31]);
        end
    endtask

    // Drive at a falling edge; results are sampled at the next falling edge.
    task automatic apply(input string req, input logic [2:0] code, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] k);
        logic [31:0] er;
        logic        et;
        model(code, a, b, k, er, et);
        in_valid = 1'b1; op = code; rs_val = a; rt_val = b; imm = k;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " result"}, result, er);
        check({req, " trap"}, {31'b0, ovf_trap}, {31'b0, et});
        check({req, " valid"}, {31'b0, out_valid}, 32'd1);
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b0; op = 3'd0; rs_val = '0; rt_val = '0; imm = '0;
        repeat (3) @(negedge clk);
        check("R1 result", result, 32'h0);
        check("R1 valid", {31'b0, out_valid}, 32'd0);
        check("R1 trap", {31'b0, ovf_trap}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", {31'b0, out_valid}, 32'd0);
    endtask

    task automatic t_add;
        apply("R2 add", 3'd0, 32'd100, 32'd23, 16'h0);
        apply("R2 addu", 3'd1, 32'hFFFF_FFF0, 32'h0000_0020, 16'h0);
        apply("R2 add neg", 3'd0, 32'hFFFF_FFFE, 32'hFFFF_FFFD, 16'h0);
    endtask

    task automatic t_sub;
        apply("R3 sub", 3'd4, 32'd50, 32'd75, 16'h0);
        apply("R3 subu", 3'd5, 32'd0, 32'd1, 16'h0);
    endtask

    task automatic t_imm;
        apply("R4 addi -10", 3'd2, 32'd4, 32'hDEAD_BEEF, 16'hFFF6);
        apply("R4 addiu pos", 3'd3, 32'h1234_0000, 32'h7FFF_FFFF, 16'h7FFF);
        apply("R4 addi rt ignored", 3'd2, 32'h7FFF_FFF0, 32'h8000_0000, 16'h0001);
    endtask

    task automatic t_ovf;
        apply("R5 R8 add pos ovf", 3'd0, 32'h7FFF_FFFF, 32'd1, 16'h0);
        apply("R5 R8 add neg ovf", 3'd0, 32'h8000_0000, 32'h8000_0000, 16'h0);
        apply("R5 add no ovf mixed", 3'd0, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0);
        apply("R5 R8 addi ovf", 3'd2, 32'h7FFF_FFF0, 32'h0, 16'h0010);
        apply("R5 addi neg ovf", 3'd2, 32'h8000_0000, 32'h0, 16'hFFFF);
        apply("R6 R8 sub ovf", 3'd4, 32'h8000_0000, 32'd1, 16'h0);
        apply("R6 sub ovf min", 3'd4, 32'h0, 32'h8000_0000, 16'h0);
        apply("R6 sub no ovf same sign", 3'd4, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0);
    endtask

    task automatic t_unsigned_wrap;
        apply("R7 addu wrap", 3'd1, 32'h7FFF_FFFF, 32'd1, 16'h0);
        apply("R7 addu neg wrap", 3'd1, 32'h8000_0000, 32'h8000_0000, 16'h0);
        apply("R7 addiu wrap", 3'd3, 32'h7FFF_FFF0, 32'h0, 16'h0010);
        apply("R7 subu wrap", 3'd5, 32'h8000_0000, 32'd1, 16'h0);
    endtask

    task automatic t_reserved;
        apply("R11 code6", 3'd6, 32'h7FFF_FFFF, 32'd1, 16'h1234);
        apply("R11 code7", 3'd7, 32'h8000_0000, 32'h8000_0000, 16'hFFFF);
    endtask

    task automatic t_timing;
        logic [31:0] er;
        logic        et;
        // Overflowing op, then idle cycle with different inputs on the bus.
        apply("R9 trap op", 3'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 16'h0);
        model(3'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 16'h0, er, et);
        op = 3'd4; rs_val = 32'h1; rt_val = 32'h2;
        @(negedge clk);
        check("R10 hold result", result, er);
        check("R9 trap one cycle", {31'b0, ovf_trap}, 32'd0);
        check("R9 valid drops", {31'b0, out_valid}, 32'd0);
        // Back-to-back: trap, no trap, trap.
        apply("R9 b2b 1", 3'd4, 32'h8000_0000, 32'd5, 16'h0);
        apply("R9 b2b 2", 3'd5, 32'h8000_0000, 32'd5, 16'h0);
        apply("R9 b2b 3", 3'd2, 32'h8000_0000, 32'h0, 16'h8000);
        @(negedge clk);
        check("R10 idle trap low", {31'b0, ovf_trap}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_imm();
        t_ovf();
        t_unsigned_wrap();
        t_reserved();
        t_timing();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule